// File: doc/BRIEF.md
# Real-Mode Address Translator with Bit-20 Gate

This block forms a physical byte address from a 16-bit segment and a 16-bit offset. The segment is moved up by four bit positions and the offset is added to it, which gives a 21-bit result. The top result is 0x10FFEF, so the block can reach a little over one megabyte (1,114,096 bytes).

A single gate input decides what happens to address bit 20. While the gate is low, bit 20 of the delivered address is held at zero. Anything that adds up to one megabyte or more then folds back onto the bottom of memory, as older software expects. While the gate is high, the extra space just above one megabyte is reachable.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, through one register stage. Each result carries three things:
- the unmasked sum;
- the gated address;
- a flag showing that the unmasked sum reached bit 20.

Back-pressure rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A request counts only in a cycle where both `in_valid` and `in_ready` are high.
- While `out_valid` is high and `out_ready` is low, the result holds steady and no new request is taken.
- The gate is sampled together with each accepted request, so a gate change affects only later translations.

Top module: `rmx_translate`

## Requirements
- R1: Right after reset `out_valid` is 0 and `in_ready` is 1, so the gate is treated as off until a request samples it.
- R2: `out_raw` equals (segment × 16) + offset as a 21-bit unsigned sum of the accepted request; for example FFFF:FFFF gives 0x10FFEF.
- R3: With the gate sampled low, `out_addr[20]` is 0 and `out_addr[19:0]` equals `out_raw[19:0]`; for example FFFF:0010 gives 0x000000 and FFFF:0011 gives 0x000001.
- R4: With the gate sampled high, `out_addr` equals `out_raw`, so 0x100000 through 0x10FFEF pass unchanged.
- R5: `out_carry` is 1 exactly when bit 20 of `out_raw` is 1, whatever the gate.
- R6: A request accepted at a clock edge shows up on the outputs with `out_valid` high right after that edge, one cycle of latency; with `out_ready` held high a new request is accepted every cycle.
- R7: `in_ready` = !`out_valid` || `out_ready`; while the output is stalled the offered request is not taken.
- R8: While `out_valid` is high and `out_ready` is low, all result outputs stay stable, even if the gate or the request inputs change.
- R9: When a result is taken and no new request is accepted in the same cycle, `out_valid` falls after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be accepted |
| in_seg | input | 16 | Segment value |
| in_off | input | 16 | Offset value |
| gate_en | input | 1 | Bit-20 gate, sampled with each accepted request |
| out_valid | output | 1 | Result held in the output register |
| out_ready | input | 1 | Consumer takes the result |
| out_raw | output | 21 | Unmasked sum |
| out_addr | output | 21 | Address after the bit-20 gate |
| out_carry | output | 1 | Unmasked sum reached bit 20 |

## Verification
Some behaviour is checked by the assertions on every cycle:
- the sum of each accepted request;
- result presence one edge after acceptance;
- result stability during a stall;
- the rule that the gated address can differ from the sum only by a cleared bit 20.

Other behaviour only the bench's scenarios can show. These are the exact wrap cases at FFFF:0010 and FFFF:0011, the pass-through at the top of the range, and the use of the gate value sampled at acceptance rather than the current one. Random segment, offset, gate and stall patterns are compared against bench functions.

// File: rtl/rmx_pkg.sv
package rmx_pkg;
  parameter int SEG_W  = 16;
  parameter int OFF_W  = 16;
  parameter int SHIFT  = 4;
  localparam int ADDR_W = SEG_W + SHIFT + 1;

  typedef struct packed {
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] addr;
    logic              carry;
  } rmx_res_t;
endpackage

// File: rtl/rmx_sum.sv
module rmx_sum
  import rmx_pkg::*;
(
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] sum,
  output logic              carry
);
  localparam int SEG_PAD = ADDR_W - SEG_W - SHIFT;
  localparam int OFF_PAD = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  always_comb begin
    seg_ext = {{SEG_PAD{1'b0}}, seg, {SHIFT{1'b0}}};
    off_ext = {{OFF_PAD{1'b0}}, off};
    sum     = seg_ext + off_ext;
    carry   = sum[ADDR_W-1];
  end
endmodule

// File: rtl/rmx_gate.sv
module rmx_gate
  import rmx_pkg::*;
(
  input  logic [ADDR_W-1:0] raw,
  input  logic              gate,
  output logic [ADDR_W-1:0] gated
);
  always_comb begin
    gated             = raw;
    gated[ADDR_W-1]   = raw[ADDR_W-1] & gate;
  end
endmodule

// File: rtl/rmx_stage.sv
module rmx_stage
  import rmx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  rmx_res_t in_data,
  output logic     out_valid,
  input  logic     out_ready,
  output rmx_res_t out_data
);
  logic accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: an accepted request is presented after the next edge
  assert_accept_presents_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8: a stalled result does not move
  assert_stall_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/rmx_translate.sv
module rmx_translate
  import rmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [OFF_W-1:0]  in_off,
  input  logic              gate_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_raw,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_carry
);
  logic [ADDR_W-1:0] sum_w;
  logic              carry_w;
  logic [ADDR_W-1:0] gated_w;
  rmx_res_t          res_in;
  rmx_res_t          res_out;

  rmx_sum u_sum (
    .seg   (in_seg),
    .off   (in_off),
    .sum   (sum_w),
    .carry (carry_w)
  );

  rmx_gate u_gate (
    .raw   (sum_w),
    .gate  (gate_en),
    .gated (gated_w)
  );

  always_comb begin
    res_in.raw   = sum_w;
    res_in.addr  = gated_w;
    res_in.carry = carry_w;
  end

  rmx_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (res_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (res_out)
  );

  assign out_raw   = res_out.raw;
  assign out_addr  = res_out.addr;
  assign out_carry = res_out.carry;

  // R2: sum of the request accepted at the previous edge
  assert_sum_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_raw ==
      ({{(ADDR_W-SEG_W-SHIFT){1'b0}}, $past(in_seg), {SHIFT{1'b0}}} +
       {{(ADDR_W-OFF_W){1'b0}}, $past(in_off)}));

  // R3 / R4: gating may only clear bit 20, never set it or touch low bits
  assert_gate_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_addr[ADDR_W-2:0] == out_raw[ADDR_W-2:0]) &&
                   (!out_addr[ADDR_W-1] || out_raw[ADDR_W-1])));

  // R4: gate high at acceptance passes the sum unchanged
  assert_gate_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && gate_en) |=> (out_addr == out_raw));
endmodule

// File: tb/rmx_translate_tb_top.sv
module rmx_translate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_seg;
  logic [15:0] in_off;
  logic        gate_en;
  logic        out_valid;
  logic        out_ready;
  logic [20:0] out_raw;
  logic [20:0] out_addr;
  logic        out_carry;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rmx_translate dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_seg(in_seg), .in_off(in_off), .gate_en(gate_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_raw(out_raw), .out_addr(out_addr), .out_carry(out_carry)
  );

  function automatic logic [20:0] f_raw(input logic [15:0] s, input logic [15:0] o);
    return {1'b0, s, 4'b0} + {5'b0, o};
  endfunction

  function automatic logic [20:0] f_gated(input logic [15:0] s, input logic [15:0] o,
                                          input logic g);
    logic [20:0] r;
    r = f_raw(s, o);
    return {r[20] & g, r[19:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_result(input logic [15:0] s, input logic [15:0] o, input logic g);
    chk("R6 out_valid", {31'b0, out_valid}, 32'd1);
    chk("R2 raw", {11'b0, out_raw}, {11'b0, f_raw(s, o)});
    if (g) chk("R4 addr", {11'b0, out_addr}, {11'b0, f_gated(s, o, g)});
    else   chk("R3 addr", {11'b0, out_addr}, {11'b0, f_gated(s, o, g)});
    chk("R5 carry", {31'b0, out_carry}, {31'b0, f_raw(s, o) >> 20});
  endtask

  // one transfer, optional stall, then drain
  task automatic xfer(input logic [15:0] s, input logic [15:0] o, input logic g,
                      input int stall);
    @(negedge clk);
    in_valid = 1'b1; in_seg = s; in_off = o; gate_en = g; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(s, o, g);
    if (stall > 0) begin
      out_ready = 1'b0;
      in_valid = 1'b1; in_seg = ~s; in_off = ~o; gate_en = ~g;
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk("R7 in_ready stalled", {31'b0, in_ready}, 32'd0);
        check_result(s, o, g);   // R8 held
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
    end
    @(negedge clk);
    chk("R9 out_valid drop", {31'b0, out_valid}, 32'd0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] bs[3];
    logic [15:0] bo[3];
    logic        bg[3];
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; in_seg = '0; in_off = '0;
    gate_en = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid reset", {31'b0, out_valid}, 32'd0);
    chk("R1 in_ready reset", {31'b0, in_ready}, 32'd1);

    // directed corners
    xfer(16'hFFFF, 16'h0010, 1'b0, 0);   // R3 wrap to 0
    xfer(16'hFFFF, 16'h0011, 1'b0, 0);   // R3 wrap to 1
    xfer(16'hFFFF, 16'h0010, 1'b1, 0);   // R4 0x100000
    xfer(16'hFFFF, 16'hFFFF, 1'b1, 0);   // R4 0x10FFEF
    xfer(16'hFFFF, 16'hFFFF, 1'b0, 2);   // R3 + R8 stall
    xfer(16'h0000, 16'h0000, 1'b1, 0);
    xfer(16'hF000, 16'hFFFF, 1'b0, 0);   // R5 no carry at 0xFFFFF

    // R6 back-to-back throughput
    for (int i = 0; i < 3; i++) begin
      bs[i] = 16'($urandom); bo[i] = 16'($urandom); bg[i] = 1'($urandom);
    end
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_seg = bs[i]; in_off = bo[i]; gate_en = bg[i];
      @(negedge clk);
      chk("R7 in_ready streaming", {31'b0, in_ready}, 32'd1);
      check_result(bs[i], bo[i], bg[i]);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 out_valid after burst", {31'b0, out_valid}, 32'd0);

    // random
    for (int i = 0; i < 300; i++) begin
      logic [15:0] s;
      logic [15:0] o;
      s = 16'($urandom);
      o = 16'($urandom);
      if ($urandom_range(3) == 0) s = 16'hF000 | 16'($urandom_range(16'h0FFF));
      xfer(s, o, 1'($urandom), int'($urandom_range(3)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule